// File: doc/BRIEF.md
# Auto-Negotiation Arbitration Sequencer

This block runs the top-level sequence of a backplane Ethernet auto-negotiation session. It starts with a transmit-disable interval and moves through ability detection, acknowledgement and the completion handshake. It then waits for the PCS to report receive link on the agreed protocol before it declares the link up. The page exchange itself and the priority resolution happen elsewhere. This block only sees their results as single-bit indications and a one-hot protocol selection.

For each protocol the block drives a 2-bit link-control code that connects or disconnects that protocol's PCS. It emits a one-cycle pulse when negotiation starts and another when the link-check phase starts. It also raises a completion flag and a parallel-detection fault flag. Control inputs let software keep the block off, bypass negotiation with every PCS connected, or restart the sequence from any state. The hold interval and the link-fail interval are parameters, so a testbench can shorten them.

Top module: `an_arb`

## Requirements
- R1: After reset, every link-control field is 00, both start pulses are 0, and complete_o and pd_fault_o are 0.
- R2: While enable_i is low, every link-control field reads 00 on the next clock and stays there, complete_o is 0, and the page indications have no effect.
- R3: With enable_i high and bypass_i high, every link-control field reads 11 on the next clock and no start pulse is produced. The code 10 is never driven on any field. Protocol k's field sits at link_ctrl_o[2k+1:2k].
- R4: Entering the transmit-disable phase, whether from off, from bypass, after a restart, after a failure or after a fault, raises tx_dis_start_o for exactly one clock. The phase lasts BREAK_CYCLES clocks with all fields at 00.
- R5: During ability detect, acknowledge detect and complete acknowledge, every field is 01, and rf_adv_o follows local_fault_i. In all other phases rf_adv_o is 0.
- R6: The phases advance in a fixed order. ability_match_i moves ability detect to acknowledge detect. ack_match_i moves that to complete acknowledge. xchg_done_i moves that to the link check. An indication that arrives in any other phase is ignored.
- R7: On entry to the link check, good_chk_start_o is high for exactly one clock. The protocol selected by resolved_i (latched at entry) reads 11, and every other protocol reads 00.
- R8: complete_o rises only on the clock after rx_link_i was seen high during the link check. If rx_link_i falls while complete, the block returns to transmit-disable.
- R9: If rx_link_i stays low for FAIL_CYCLES clocks of the link check, the block returns to transmit-disable.
- R10: restart_i (with enable_i high and bypass_i low) sends the block to transmit-disable on the next clock from any phase. Holding restart_i in transmit-disable reloads the hold interval without a second pulse.
- R11: If more than one pd_link_i bit is high during ability detect, pd_fault_o is set and the block returns to transmit-disable. pd_fault_o clears on restart_i or when enable_i is low.
- R12: If resolved_i is all zero when xchg_done_i arrives, the block returns to transmit-disable instead of entering the link check.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| enable_i | input | 1 | Negotiation enable |
| bypass_i | input | 1 | Skip negotiation, connect every PCS |
| restart_i | input | 1 | Restart negotiation from any phase |
| local_fault_i | input | 1 | Local fault, advertised as remote fault |
| ability_match_i | input | 1 | Partner abilities detected |
| ack_match_i | input | 1 | Partner acknowledge detected |
| xchg_done_i | input | 1 | Page exchange finished |
| resolved_i | input | NUM_PROT | One-hot resolved protocol |
| pd_link_i | input | NUM_PROT | Per-protocol parallel-detect link seen |
| rx_link_i | input | 1 | PCS receive link status for the resolved protocol |
| link_ctrl_o | output | 2*NUM_PROT | Per-protocol link-control codes |
| tx_dis_start_o | output | 1 | One-clock pulse on entering transmit-disable |
| good_chk_start_o | output | 1 | One-clock pulse on entering link check |
| complete_o | output | 1 | Negotiation complete with receive link |
| pd_fault_o | output | 1 | Parallel-detection fault |
| rf_adv_o | output | 1 | Remote-fault bit to advertise |

## Verification
A table walks one full session in which every page indication also arrives once out of turn. This distinguishes a machine that keys on phase from one that reacts to any indication. The same table covers bypass, disable and restart from off, which separates the override priorities from normal progress. Directed runs then let the link check time out and deliver an all-zero resolution. These show whether failures return to transmit-disable with a fresh pulse. A held restart separates hold-interval reload from re-pulsing, and two simultaneous parallel-detect links check both the fault flag and the way it clears.

// File: rtl/an_arb_pkg.sv
package an_arb_pkg;
  typedef enum logic [2:0] {
    ST_OFF, ST_BYPASS, ST_TX_DIS, ST_ABIL, ST_ACK, ST_CACK, ST_GCHK, ST_GOOD
  } an_state_e;

  localparam logic [1:0] LC_DISABLE = 2'b00;
  localparam logic [1:0] LC_SCAN    = 2'b01;
  localparam logic [1:0] LC_ENABLE  = 2'b11;
endpackage

// File: rtl/an_arb_timer.sv
module an_arb_timer #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] val_i,
  output logic         done_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          cnt_q <= '0;
    else if (load_i)      cnt_q <= val_i;
    else if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
  end

  assign done_o = (cnt_q == '0);
endmodule

// File: rtl/an_arb_fsm.sv
module an_arb_fsm
  import an_arb_pkg::*;
#(
  parameter int NUM_PROT     = 4,
  parameter int BREAK_CYCLES = 1000,
  parameter int FAIL_CYCLES  = 5000
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                enable_i,
  input  logic                bypass_i,
  input  logic                restart_i,
  input  logic                ability_match_i,
  input  logic                ack_match_i,
  input  logic                xchg_done_i,
  input  logic [NUM_PROT-1:0] resolved_i,
  input  logic [NUM_PROT-1:0] pd_link_i,
  input  logic                rx_link_i,
  output an_state_e           state_o,
  output logic [NUM_PROT-1:0] sel_o,
  output logic                tx_dis_start_o,
  output logic                good_chk_start_o,
  output logic                pd_fault_o
);
  localparam int MAXC = (BREAK_CYCLES > FAIL_CYCLES) ? BREAK_CYCLES : FAIL_CYCLES;
  localparam int TW   = $clog2(MAXC + 1);

  an_state_e           state_q, state_d;
  logic [NUM_PROT-1:0] sel_q;
  logic                txp_q, gcp_q, pdf_q;
  logic                run, pd_multi, t_done, t_load;
  logic [TW-1:0]       t_val;

  assign run      = enable_i && !bypass_i && !restart_i;
  assign pd_multi = (state_q == ST_ABIL) && ($countones(pd_link_i) > 1);

  always_comb begin
    state_d = state_q;
    if (!enable_i)      state_d = ST_OFF;
    else if (bypass_i)  state_d = ST_BYPASS;
    else if (restart_i) state_d = ST_TX_DIS;
    else begin
      unique case (state_q)
        ST_OFF, ST_BYPASS: state_d = ST_TX_DIS;
        ST_TX_DIS: if (t_done) state_d = ST_ABIL;
        ST_ABIL: begin
          if (pd_multi)             state_d = ST_TX_DIS;
          else if (ability_match_i) state_d = ST_ACK;
        end
        ST_ACK:  if (ack_match_i) state_d = ST_CACK;
        ST_CACK: if (xchg_done_i) state_d = (resolved_i == '0) ? ST_TX_DIS : ST_GCHK;
        ST_GCHK: begin
          if (rx_link_i)   state_d = ST_GOOD;
          else if (t_done) state_d = ST_TX_DIS;
        end
        ST_GOOD: if (!rx_link_i) state_d = ST_TX_DIS;
        default: state_d = ST_OFF;
      endcase
    end
  end

  // reload on entry, and on a restart held inside transmit-disable
  assign t_load = (state_d != state_q) || (enable_i && !bypass_i && restart_i);
  assign t_val  = (state_d == ST_GCHK) ? TW'(FAIL_CYCLES - 1) : TW'(BREAK_CYCLES - 1);

  an_arb_timer #(.W(TW)) u_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (t_load),
    .val_i  (t_val),
    .done_o (t_done)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_OFF;
      sel_q   <= '0;
      txp_q   <= 1'b0;
      gcp_q   <= 1'b0;
      pdf_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      txp_q   <= (state_d == ST_TX_DIS) && (state_q != ST_TX_DIS);
      gcp_q   <= (state_d == ST_GCHK) && (state_q != ST_GCHK);
      if (state_q == ST_CACK && state_d == ST_GCHK) sel_q <= resolved_i;
      if (!enable_i || restart_i)  pdf_q <= 1'b0;
      else if (run && pd_multi)    pdf_q <= 1'b1;
    end
  end

  assign state_o          = state_q;
  assign sel_o            = sel_q;
  assign tx_dis_start_o   = txp_q;
  assign good_chk_start_o = gcp_q;
  assign pd_fault_o       = pdf_q;
endmodule

// File: rtl/an_arb_lc.sv
module an_arb_lc
  import an_arb_pkg::*;
#(
  parameter int NUM_PROT = 4
) (
  input  an_state_e             state_i,
  input  logic [NUM_PROT-1:0]   sel_i,
  output logic [2*NUM_PROT-1:0] lc_o
);
  for (genvar k = 0; k < NUM_PROT; k++) begin : g_prot
    always_comb begin
      unique case (state_i)
        ST_ABIL, ST_ACK, ST_CACK: lc_o[2*k+1 -: 2] = LC_SCAN;
        ST_GCHK, ST_GOOD:         lc_o[2*k+1 -: 2] = sel_i[k] ? LC_ENABLE : LC_DISABLE;
        ST_BYPASS:                lc_o[2*k+1 -: 2] = LC_ENABLE;
        default:                  lc_o[2*k+1 -: 2] = LC_DISABLE;
      endcase
    end
  end
endmodule

// File: rtl/an_arb.sv
module an_arb
  import an_arb_pkg::*;
#(
  parameter int NUM_PROT     = 4,
  parameter int BREAK_CYCLES = 1000,
  parameter int FAIL_CYCLES  = 5000
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  enable_i,
  input  logic                  bypass_i,
  input  logic                  restart_i,
  input  logic                  local_fault_i,
  input  logic                  ability_match_i,
  input  logic                  ack_match_i,
  input  logic                  xchg_done_i,
  input  logic [NUM_PROT-1:0]   resolved_i,
  input  logic [NUM_PROT-1:0]   pd_link_i,
  input  logic                  rx_link_i,
  output logic [2*NUM_PROT-1:0] link_ctrl_o,
  output logic                  tx_dis_start_o,
  output logic                  good_chk_start_o,
  output logic                  complete_o,
  output logic                  pd_fault_o,
  output logic                  rf_adv_o
);
  an_state_e           state;
  logic [NUM_PROT-1:0] sel;

  an_arb_fsm #(
    .NUM_PROT     (NUM_PROT),
    .BREAK_CYCLES (BREAK_CYCLES),
    .FAIL_CYCLES  (FAIL_CYCLES)
  ) u_fsm (
    .clk_i            (clk_i),
    .rst_ni           (rst_ni),
    .enable_i         (enable_i),
    .bypass_i         (bypass_i),
    .restart_i        (restart_i),
    .ability_match_i  (ability_match_i),
    .ack_match_i      (ack_match_i),
    .xchg_done_i      (xchg_done_i),
    .resolved_i       (resolved_i),
    .pd_link_i        (pd_link_i),
    .rx_link_i        (rx_link_i),
    .state_o          (state),
    .sel_o            (sel),
    .tx_dis_start_o   (tx_dis_start_o),
    .good_chk_start_o (good_chk_start_o),
    .pd_fault_o       (pd_fault_o)
  );

  an_arb_lc #(.NUM_PROT(NUM_PROT)) u_lc (
    .state_i (state),
    .sel_i   (sel),
    .lc_o    (link_ctrl_o)
  );

  assign complete_o = (state == ST_GOOD);
  assign rf_adv_o   = local_fault_i &&
                      (state == ST_ABIL || state == ST_ACK || state == ST_CACK);
endmodule

// File: rtl/an_arb_chk.sv
module an_arb_chk #(
  parameter int NUM_PROT = 4
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic                  enable_i,
  input logic                  bypass_i,
  input logic                  restart_i,
  input logic                  rx_link_i,
  input logic [2*NUM_PROT-1:0] link_ctrl_o,
  input logic                  tx_dis_start_o,
  input logic                  good_chk_start_o,
  input logic                  complete_o
);
  // R2
  disabled_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !enable_i |=> (link_ctrl_o == '0) && !complete_o);

  // R3
  bypass_all_on_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (enable_i && bypass_i) |=> (link_ctrl_o == '1) && !tx_dis_start_o && !good_chk_start_o);

  for (genvar k = 0; k < NUM_PROT; k++) begin : g_code
    // R3
    no_code10_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      link_ctrl_o[2*k+1 -: 2] != 2'b10);
  end

  // R4
  txd_pulse_one_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_dis_start_o |=> !tx_dis_start_o);

  // R7
  gchk_pulse_one_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    good_chk_start_o |=> !good_chk_start_o);

  // R8
  complete_link_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(complete_o) |-> $past(rx_link_i));

  // R10
  restart_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (enable_i && !bypass_i && restart_i) |=> (link_ctrl_o == '0) && !complete_o);
endmodule

bind an_arb an_arb_chk #(.NUM_PROT(NUM_PROT)) u_chk (
  .clk_i            (clk_i),
  .rst_ni           (rst_ni),
  .enable_i         (enable_i),
  .bypass_i         (bypass_i),
  .restart_i        (restart_i),
  .rx_link_i        (rx_link_i),
  .link_ctrl_o      (link_ctrl_o),
  .tx_dis_start_o   (tx_dis_start_o),
  .good_chk_start_o (good_chk_start_o),
  .complete_o       (complete_o)
);

// File: tb/an_arb_test.sv
module an_arb_test;
  localparam int CLK_PERIOD = 10;
  localparam int NP = 4;
  localparam int BRK = 3;
  localparam int FAIL = 4;

  logic clk_i = 0, rst_ni = 0;
  logic enable_i = 0, bypass_i = 0, restart_i = 0, local_fault_i = 0;
  logic ability_match_i = 0, ack_match_i = 0, xchg_done_i = 0, rx_link_i = 0;
  logic [NP-1:0] resolved_i = 4'b0100, pd_link_i = '0;
  logic [2*NP-1:0] link_ctrl_o;
  logic tx_dis_start_o, good_chk_start_o, complete_o, pd_fault_o, rf_adv_o;

  int total = 0, failed = 0;
  bit done = 0;

  an_arb #(.NUM_PROT(NP), .BREAK_CYCLES(BRK), .FAIL_CYCLES(FAIL)) uut (.*);

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  // inputs {en,byp,rst,abil,ack,done,link}, expected {lc[7:0], txp, gcp, cmp}
  localparam logic [17:0] VEC [18] = '{
    {7'b1000000, 8'h00, 3'b100},  // R4 enter tx-disable
    {7'b1000000, 8'h00, 3'b000},
    {7'b1000000, 8'h00, 3'b000},
    {7'b1000000, 8'h55, 3'b000},  // R5 ability detect
    {7'b1000100, 8'h55, 3'b000},  // R6 ack ignored
    {7'b1001000, 8'h55, 3'b000},  // R6 to ack detect
    {7'b1000010, 8'h55, 3'b000},  // R6 done ignored
    {7'b1000100, 8'h55, 3'b000},  // R6 to complete ack
    {7'b1000010, 8'h30, 3'b010},  // R7 link check
    {7'b1000000, 8'h30, 3'b000},
    {7'b1000001, 8'h30, 3'b001},  // R8 complete
    {7'b1000001, 8'h30, 3'b001},
    {7'b1000000, 8'h00, 3'b100},  // R8 link drop
    {7'b1100000, 8'hFF, 3'b000},  // R3 bypass
    {7'b1101000, 8'hFF, 3'b000},
    {7'b0000000, 8'h00, 3'b000},  // R2 disabled
    {7'b0001000, 8'h00, 3'b000},
    {7'b1010000, 8'h00, 3'b100}   // R10 restart from off
  };

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      failed++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk_i);
    @(negedge clk_i);
  endtask

  task automatic clr_ind();
    {restart_i, ability_match_i, ack_match_i, xchg_done_i, rx_link_i} = '0;
  endtask

  task automatic run_to_cack();
    clr_ind();
    enable_i = 0; bypass_i = 0; cyc();
    enable_i = 1;
    for (int i = 0; i < BRK + 1; i++) cyc();
    ability_match_i = 1; cyc();
    ability_match_i = 0; ack_match_i = 1; cyc();
    ack_match_i = 0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", total - failed, total);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    total++; failed++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    @(negedge clk_i); @(negedge clk_i);
    chk("R1 lc", 32'(link_ctrl_o), 0);
    chk("R1 pulses/flags", {tx_dis_start_o, good_chk_start_o, complete_o, pd_fault_o}, 0);
    rst_ni = 1;
    @(negedge clk_i);

    for (int i = 0; i < 18; i++) begin
      {enable_i, bypass_i, restart_i, ability_match_i, ack_match_i, xchg_done_i, rx_link_i} = VEC[i][17:11];
      cyc();
      chk($sformatf("R2/R3/R4/R6/R7/R8 vec %0d lc", i), 32'(link_ctrl_o), 32'(VEC[i][10:3]));
      chk($sformatf("R4/R7/R8 vec %0d pulses", i),
          {tx_dis_start_o, good_chk_start_o, complete_o}, 32'(VEC[i][2:0]));
    end

    // R9 link-fail timeout
    run_to_cack();
    resolved_i = 4'b0100; xchg_done_i = 1; cyc(); xchg_done_i = 0;
    chk("R9 entry", {link_ctrl_o, good_chk_start_o}, {8'h30, 1'b1});
    for (int i = 0; i < FAIL - 1; i++) cyc();
    chk("R9 still checking", 32'(link_ctrl_o), 32'h30);
    cyc();
    chk("R9 timeout", {link_ctrl_o, tx_dis_start_o}, {8'h00, 1'b1});

    // R12 empty resolution
    run_to_cack();
    resolved_i = '0; xchg_done_i = 1; cyc(); xchg_done_i = 0;
    chk("R12 back to tx-disable", {link_ctrl_o, tx_dis_start_o, good_chk_start_o}, {8'h00, 2'b10});
    resolved_i = 4'b0100;

    // R10 restart and held restart
    run_to_cack();
    restart_i = 1; cyc();
    chk("R10 restart", {link_ctrl_o, tx_dis_start_o}, {8'h00, 1'b1});
    cyc();
    chk("R10 held no repulse", {link_ctrl_o, tx_dis_start_o}, {8'h00, 1'b0});
    restart_i = 0; cyc(); cyc();
    chk("R10 hold reloaded", 32'(link_ctrl_o), 0);
    cyc();
    chk("R10 ability after hold", 32'(link_ctrl_o), 32'h55);

    // R5 remote fault advertisement
    local_fault_i = 1; #1;
    chk("R5 rf in ability", 32'(rf_adv_o), 1);

    // R11 parallel detect fault
    @(negedge clk_i);
    pd_link_i = 4'b0011; cyc(); pd_link_i = '0;
    chk("R11 fault set", {pd_fault_o, tx_dis_start_o, link_ctrl_o}, {2'b11, 8'h00});
    chk("R5 rf off in tx-disable", 32'(rf_adv_o), 0);
    restart_i = 1; cyc(); restart_i = 0;
    chk("R11 fault cleared", 32'(pd_fault_o), 0);
    local_fault_i = 0;

    // R2 disable mid-negotiation
    run_to_cack();
    enable_i = 0; xchg_done_i = 1; cyc();
    chk("R2 disable", {link_ctrl_o, complete_o, good_chk_start_o}, 0);
    cyc();
    chk("R2 done ignored", {link_ctrl_o, good_chk_start_o}, 0);
    clr_ind();

    finish_run();
  end
endmodule